// File: doc/BRIEF.md
# Quad DAC Serial Command Sender

This block lets on-chip logic program a four-channel 8-bit serial DAC. A client hands it one command at a time over a ready/valid request: a channel number, a range (gain) bit, an 8-bit code and a flag that selects between an immediate and a deferred output update. The block serialises the command onto a generated serial clock and data line, then strobes the load line to latch it into the converter.

The load-DAC line is driven in one of two ways. For an immediate command it is held low for the whole transfer, so the converter output moves as soon as the load strobe falls. For a deferred command it stays high, so the value is only staged. A separate update request later pulses the load-DAC line low for one bit period, and all four channels change together. The serial clock runs at a fixed ratio of the system clock, set by one parameter.

Top module: `qdac_cmd_tx`

## Requirements
- R1: Out of reset and whenever the block is idle, the serial clock, load line and load-DAC line are all high, busy is low and done is low.
- R2: Each command sends exactly 11 bits, first bit first: channel[1] is sent first, then channel[0], then the range bit, then value[7] down to value[0].
- R3: The data line only changes while the serial clock is high, so it is stable across every falling edge, where the converter samples it.
- R4: Every bit period is a high half followed by a low half, each exactly HALF_CLKS system clocks long.
- R5: The load line stays high during shifting, falls once after the eleventh falling clock edge while the serial clock is high, and stays low for exactly 2*HALF_CLKS system clocks.
- R6: For an immediate command (defer flag 0) the load-DAC line is low when the load line falls, and it forms one low run of 12 bit periods; for a deferred command (defer flag 1) the load-DAC line stays high for the whole command.
- R7: An update request accepted while idle drives the load-DAC line low for exactly 2*HALF_CLKS system clocks, with busy high and no activity on the load line.
- R8: Busy rises in the cycle after a request is accepted and falls when the load or update pulse ends; done is high for exactly one cycle at that moment; command ready is low while busy.
- R9: When an update request and a command request are both present in an idle cycle, the update is taken first: command ready is low in that cycle and the command is sent after the update pulse.
- R10: An update request raised while busy is ignored: it produces no low pulse on the load-DAC line then or later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Command request present |
| req_ready | output | 1 | Command request accepted at this edge when valid |
| req_chan | input | 2 | Target channel, 0 to 3 |
| req_range | input | 1 | Range (gain) bit sent with the code |
| req_value | input | 8 | Converter code |
| req_defer | input | 1 | 1: stage only, 0: update output at once |
| upd_valid | input | 1 | Request to pulse the load-DAC line (taken only when idle) |
| sclk | output | 1 | Serial clock to the converter, idles high |
| sdata | output | 1 | Serial data to the converter |
| load_n | output | 1 | Active-low command latch strobe |
| ldac_n | output | 1 | Active-low converter output update line |
| busy | output | 1 | A command or update pulse is in progress |
| done | output | 1 | One-cycle pulse when a command or update finishes |

## Verification
The two functions that can meet in one cycle are a command request and an all-channel update request, both offered to an idle block. The bench raises both on the same cycle and expects command ready to read low, a single update pulse of one bit period, and only afterwards the full command frame with its load strobe. It also raises an update request in the middle of a deferred command and expects the load-DAC line never to fall, which separates an ignored request from one queued by mistake.

// File: rtl/qdac_pkg.sv
package qdac_pkg;

    localparam int CHAN_W     = 2;
    localparam int VAL_W      = 8;
    localparam int FRAME_BITS = CHAN_W + 1 + VAL_W;
    localparam int BIT_W      = $clog2(FRAME_BITS);

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SHIFT,
        ST_LOAD,
        ST_UPD
    } qdac_state_e;

    typedef struct packed {
        qdac_state_e             state;
        logic [FRAME_BITS-1:0]   shreg;
        logic [BIT_W-1:0]        bitn;
        logic                    imm;
        logic                    done;
    } qdac_seq_t;

endpackage

// File: rtl/qdac_tick.sv
// Bit-period phase counter: a high half then a low half of HALF_CLKS each.
module qdac_tick #(
    parameter int HALF_CLKS = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic low_half,
    output logic period_end
);
    localparam int PERIOD = 2 * HALF_CLKS;
    localparam int CW     = (PERIOD > 2) ? $clog2(PERIOD) : 1;

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d      = cnt_q;
        period_end = (cnt_q == CW'(PERIOD - 1));
        low_half   = (cnt_q >= CW'(HALF_CLKS));
        if (!run) begin
            cnt_d = '0;
        end else if (period_end) begin
            cnt_d = '0;
        end else begin
            cnt_d = cnt_q + CW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/qdac_seq.sv
// Command sequencer: frame shifting, load strobe, load-DAC control.
module qdac_seq
    import qdac_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [CHAN_W-1:0] req_chan,
    input  logic              req_range,
    input  logic [VAL_W-1:0]  req_value,
    input  logic              req_defer,
    input  logic              upd_valid,
    input  logic              low_half,
    input  logic              period_end,
    output logic              run,
    output logic              sclk,
    output logic              sdata,
    output logic              load_n,
    output logic              ldac_n,
    output logic              busy,
    output logic              done
);
    qdac_seq_t r_q, r_d;

    always_comb begin
        r_d       = r_q;
        r_d.done  = 1'b0;
        req_ready = (r_q.state == ST_IDLE) && !upd_valid;

        unique case (r_q.state)
            ST_IDLE: begin
                if (upd_valid) begin
                    r_d.state = ST_UPD;
                end else if (req_valid) begin
                    r_d.state = ST_SHIFT;
                    r_d.shreg = {req_chan, req_range, req_value};
                    r_d.bitn  = '0;
                    r_d.imm   = !req_defer;
                end
            end
            ST_SHIFT: begin
                if (period_end) begin
                    r_d.shreg = {r_q.shreg[FRAME_BITS-2:0], 1'b0};
                    if (r_q.bitn == BIT_W'(FRAME_BITS - 1)) begin
                        r_d.state = ST_LOAD;
                    end else begin
                        r_d.bitn = r_q.bitn + BIT_W'(1);
                    end
                end
            end
            ST_LOAD: begin
                if (period_end) begin
                    r_d.state = ST_IDLE;
                    r_d.imm   = 1'b0;
                    r_d.done  = 1'b1;
                end
            end
            ST_UPD: begin
                if (period_end) begin
                    r_d.state = ST_IDLE;
                    r_d.done  = 1'b1;
                end
            end
            default: r_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.state <= ST_IDLE;
            r_q.shreg <= '0;
            r_q.bitn  <= '0;
            r_q.imm   <= 1'b0;
            r_q.done  <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        run    = (r_q.state != ST_IDLE);
        busy   = run;
        done   = r_q.done;
        sclk   = !((r_q.state == ST_SHIFT) && low_half);
        sdata  = (r_q.state == ST_SHIFT) ? r_q.shreg[FRAME_BITS-1] : 1'b0;
        load_n = (r_q.state != ST_LOAD);
        ldac_n = !((r_q.state == ST_UPD) ||
                   (r_q.imm && ((r_q.state == ST_SHIFT) || (r_q.state == ST_LOAD))));
    end
endmodule

// File: rtl/qdac_cmd_tx.sv
module qdac_cmd_tx #(
    parameter int HALF_CLKS = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       req_valid,
    output logic       req_ready,
    input  logic [1:0] req_chan,
    input  logic       req_range,
    input  logic [7:0] req_value,
    input  logic       req_defer,
    input  logic       upd_valid,
    output logic       sclk,
    output logic       sdata,
    output logic       load_n,
    output logic       ldac_n,
    output logic       busy,
    output logic       done
);
    logic run, low_half, period_end;

    qdac_tick #(.HALF_CLKS(HALF_CLKS)) u_tick (
        .clk        (clk),
        .rst_n      (rst_n),
        .run        (run),
        .low_half   (low_half),
        .period_end (period_end)
    );

    qdac_seq u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .req_ready  (req_ready),
        .req_chan   (req_chan),
        .req_range  (req_range),
        .req_value  (req_value),
        .req_defer  (req_defer),
        .upd_valid  (upd_valid),
        .low_half   (low_half),
        .period_end (period_end),
        .run        (run),
        .sclk       (sclk),
        .sdata      (sdata),
        .load_n     (load_n),
        .ldac_n     (ldac_n),
        .busy       (busy),
        .done       (done)
    );
endmodule

// File: rtl/qdac_cmd_tx_chk.sv
module qdac_cmd_tx_chk (
    input logic clk,
    input logic rst_n,
    input logic req_ready,
    input logic upd_valid,
    input logic sclk,
    input logic sdata,
    input logic load_n,
    input logic ldac_n,
    input logic busy,
    input logic done
);
    a_r1_idle_levels: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (sclk && load_n && ldac_n));

    a_r3_data_moves_high: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sdata) |-> sclk);

    a_r5_load_clock_high: assert property (@(posedge clk) disable iff (!rst_n)
        !load_n |-> (sclk && busy));

    a_r8_no_ready_busy: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !req_ready);

    a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r8_done_ends_busy: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ($past(busy) && !busy));

    a_r9_update_first: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_valid && !busy) |-> !req_ready);
endmodule

bind qdac_cmd_tx qdac_cmd_tx_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_ready (req_ready),
    .upd_valid (upd_valid),
    .sclk      (sclk),
    .sdata     (sdata),
    .load_n    (load_n),
    .ldac_n    (ldac_n),
    .busy      (busy),
    .done      (done)
);

// File: tb/sim_qdac_cmd_tx.sv
module sim_qdac_cmd_tx;
    localparam int H = 4;
    localparam int P = 2 * H;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0, req_range = 1'b0, req_defer = 1'b0, upd_valid = 1'b0;
    logic [1:0] req_chan = '0;
    logic [7:0] req_value = '0;
    logic req_ready, sclk, sdata, load_n, ldac_n, busy, done;

    int tests = 0, fails = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    qdac_cmd_tx #(.HALF_CLKS(H)) u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_chan(req_chan), .req_range(req_range), .req_value(req_value),
        .req_defer(req_defer), .upd_valid(upd_valid), .sclk(sclk), .sdata(sdata),
        .load_n(load_n), .ldac_n(ldac_n), .busy(busy), .done(done)
    );

    // Receiver model sampled at negedge
    logic ps = 1'b1, pl = 1'b1, pd = 1'b1;
    logic [10:0] cap = '0, last_frame = '0;
    int bitcnt = 0, lo_run = 0, hi_run = 0, ld_run = 0, dac_run = 0;
    int half_err = 0, frames = 0, ldac_runs = 0, last_dac_len = 0, load_len = 0, last_bits = 0;
    logic ldac_at_load = 1'b1, sclk_at_load = 1'b1;

    always @(negedge clk) begin
        if (rst_n) begin
            if (ps && !sclk) begin
                if (bitcnt > 0 && hi_run != H) half_err++;
                hi_run = 0;
                cap = {cap[9:0], sdata};
                bitcnt++;
            end
            if (!ps && sclk) begin
                if (lo_run != H) half_err++;
                lo_run = 0;
                hi_run = 0;
            end
            if (sclk) hi_run++; else lo_run++;
            if (pl && !load_n) begin
                last_frame = cap; last_bits = bitcnt;
                ldac_at_load = ldac_n; sclk_at_load = sclk;
                frames++; bitcnt = 0; ld_run = 0;
            end
            if (!load_n) ld_run++;
            if (!pl && load_n) load_len = ld_run;
            if (pd && !ldac_n) begin ldac_runs++; dac_run = 0; end
            if (!ldac_n) dac_run++;
            if (!pd && ldac_n) last_dac_len = dac_run;
            ps = sclk; pl = load_n; pd = ldac_n;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic [10:0] exp_frame(input logic [1:0] ch, input logic rg, input logic [7:0] v);
        return {ch, rg, v};
    endfunction

    task automatic send(input logic [1:0] ch, input logic rg, input logic [7:0] v, input logic df);
        int f0, r0;
        f0 = frames; r0 = ldac_runs;
        @(negedge clk);
        req_chan = ch; req_range = rg; req_value = v; req_defer = df; req_valid = 1'b1;
        #1;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        chk(busy && !req_ready, "R8 busy after accept", int'(busy), 1);
        while (!done) @(negedge clk);
        @(negedge clk);
        chk(!done && !busy, "R8 done single cycle", int'(done), 0);
        chk(frames == f0 + 1, "R5 one load strobe", frames - f0, 1);
        chk(last_bits == 11, "R2 bit count", last_bits, 11);
        chk(last_frame == exp_frame(ch, rg, v), "R2 frame content", int'(last_frame), int'(exp_frame(ch, rg, v)));
        chk(load_len == P, "R5 load low length", load_len, P);
        chk(sclk_at_load, "R5 clock high at load", int'(sclk_at_load), 1);
        chk(ldac_at_load == df, "R6 ldac level at load", int'(ldac_at_load), int'(df));
        if (df) begin
            chk(ldac_runs == r0, "R6 R10 deferred no ldac fall", ldac_runs - r0, 0);
        end else begin
            chk(ldac_runs == r0 + 1, "R6 immediate ldac run", ldac_runs - r0, 1);
            chk(last_dac_len == 12 * P, "R6 immediate ldac length", last_dac_len, 12 * P);
        end
        chk(half_err == 0, "R4 half period length", half_err, 0);
    endtask

    task automatic upd();
        int f0, r0;
        f0 = frames; r0 = ldac_runs;
        @(negedge clk);
        upd_valid = 1'b1;
        @(negedge clk);
        upd_valid = 1'b0;
        chk(busy && !req_ready, "R7 busy during update", int'(busy), 1);
        while (!done) @(negedge clk);
        @(negedge clk);
        chk(ldac_runs == r0 + 1, "R7 one ldac pulse", ldac_runs - r0, 1);
        chk(last_dac_len == P, "R7 ldac pulse length", last_dac_len, P);
        chk(frames == f0, "R7 no load strobe", frames - f0, 0);
        chk(!busy && ldac_n, "R1 idle after update", int'(ldac_n), 1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            fails++;
            $display("FAIL R8 watchdog actual=hang expected=finish");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h00C0FFEE));
        repeat (3) @(negedge clk);
        chk(sclk && load_n && ldac_n && !busy && !done, "R1 levels in reset", int'({sclk, load_n, ldac_n}), 7);
        rst_n = 1'b1;
        @(negedge clk);
        chk(sclk && load_n && ldac_n && !busy && req_ready, "R1 idle after reset", int'({sclk, load_n, ldac_n, busy, req_ready}), 29);

        // Directed corners
        send(2'd0, 1'b0, 8'h00, 1'b0);
        send(2'd3, 1'b1, 8'hFF, 1'b1);
        send(2'd2, 1'b0, 8'h55, 1'b1);
        send(2'd1, 1'b1, 8'hAA, 1'b0);
        upd();

        // R10: update raised mid-frame of a deferred command
        fork
            send(2'd1, 1'b0, 8'h3C, 1'b1);
            begin
                repeat (20) @(negedge clk);
                upd_valid = 1'b1;
                @(negedge clk);
                upd_valid = 1'b0;
            end
        join
        begin
            int r0;
            r0 = ldac_runs;
            repeat (3 * P) @(negedge clk);
            chk(ldac_runs == r0 && ldac_n && !busy, "R10 ignored update stays ignored", ldac_runs - r0, 0);
        end

        // R9: both requests in one idle cycle
        begin
            int f0, r0;
            f0 = frames; r0 = ldac_runs;
            @(negedge clk);
            req_chan = 2'd2; req_range = 1'b1; req_value = 8'h81; req_defer = 1'b0;
            req_valid = 1'b1; upd_valid = 1'b1;
            #1;
            chk(!req_ready, "R9 command held off", int'(req_ready), 0);
            @(negedge clk);
            upd_valid = 1'b0;
            chk(busy && !req_ready, "R9 update taken first", int'(busy), 1);
            while (!done) @(negedge clk);
            chk(frames == f0, "R9 no frame before update ends", frames - f0, 0);
            @(negedge clk);
            req_valid = 1'b0;
            chk(last_dac_len == P && ldac_runs == r0 + 1, "R9 update pulse length", last_dac_len, P);
            while (frames == f0) @(negedge clk);
            while (busy) @(negedge clk);
            @(negedge clk);
            chk(last_frame == exp_frame(2'd2, 1'b1, 8'h81), "R9 R2 command after update", int'(last_frame), int'(exp_frame(2'd2, 1'b1, 8'h81)));
            chk(ldac_runs == r0 + 2 && ldac_at_load == 1'b0, "R9 R6 immediate after update", ldac_runs - r0, 2);
        end

        // Random mix
        for (int i = 0; i < 30; i++) begin
            if ($urandom % 4 == 0) upd();
            else send(2'($urandom), 1'($urandom), 8'($urandom), 1'($urandom));
        end

        finished = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule